// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of two-word transmit descriptors in memory, hands each frame's buffer to a MAC transmit stage, and records the outcome as a one-word entry in a separate circular status ring. The host writes descriptors into the ring and then tells the engine how many new descriptors are ready through an enqueue strobe carrying a count. The engine holds a count of outstanding descriptors and serves them one at a time, strictly in ring order.

For each frame the engine reads the buffer address word, then the control word, through a single-outstanding memory request port. If the control word's abort flag is clear, the engine issues a one-cycle start to the MAC with address, length and end-of-frame flag, then waits for the MAC's done pulse and result bundle. If the abort flag is set, the MAC is skipped. Either way the engine writes a status word to the status ring, advances both ring pointers (wrapping after the last entry), decrements the outstanding count and pulses a transmit interrupt. A configuration load strobe places both rings at their base addresses.

Top module: `tx_ring_engine`

## Requirements
- R1: During and straight after reset, mem_req, mac_start and tx_irq are 0, pending is 0 and both ring pointers are 0.
- R2: An enqueue strobe adds enq_count to pending in the next cycle (a count of 0 changes nothing and starts no memory traffic); each completed frame lowers pending by one; no descriptor fetch starts while pending is 0.
- R3: A frame begins with a read of the word at desc_cur, then a read at desc_cur+4; a request stays high with a stable address until mem_gnt, and read data is taken only with mem_rvalid.
- R4: For a descriptor whose control word has bit 15 clear, mac_start is high for exactly one cycle with mac_addr equal to the first word, mac_len equal to control bits 11:0 (bits 14:12 ignored) and mac_eof equal to control bit 31.
- R5: Each frame ends with one write to stat_cur whose word has bit 31 set, bit 30 equal to the MAC "ok" result, bit 28 no carrier, bit 26 late collision, bit 25 underrun, bit 24 excess collisions, bits 20:16 collision count, bits 14:0 the control word's bits 30:16, other bits 0.
- R6: A descriptor with control bit 15 set produces no mac_start; its status word has bits 31 and 29 set, bits 30, 28, 26:24 and 20:16 clear, and bits 14:0 the echoed index.
- R7: desc_cur moves by 8 bytes at each completed frame and returns to the descriptor base after ENTRIES frames; it does not move otherwise.
- R8: stat_cur moves by 4 bytes at each completed frame and returns to the status base after ENTRIES frames; it does not move otherwise.
- R9: tx_irq is high for exactly the one cycle after each accepted status write.
- R10: cfg_load sets desc_cur and stat_cur to the supplied bases and clears pending in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load ring bases, clear pending |
| cfg_desc_base | input | 32 | Descriptor ring base byte address |
| cfg_stat_base | input | 32 | Status ring base byte address |
| enq_valid | input | 1 | Enqueue strobe |
| enq_count | input | CNT_W | Number of descriptors made ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data (status word) |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mac_start | output | 1 | One-cycle start to MAC |
| mac_addr | output | 32 | Frame buffer address |
| mac_len | output | 12 | Frame length in bytes |
| mac_eof | output | 1 | End-of-frame flag from descriptor |
| mac_done | input | 1 | MAC finished frame |
| mac_ok | input | 1 | Sent without error |
| mac_no_carrier | input | 1 | Carrier lost |
| mac_late_coll | input | 1 | Out-of-window collision |
| mac_underrun | input | 1 | Transmit underrun |
| mac_excess_coll | input | 1 | Excessive collisions |
| mac_coll_cnt | input | 5 | Collision count |
| tx_irq | output | 1 | Status-written pulse |
| desc_cur | output | 32 | Current descriptor address |
| stat_cur | output | 32 | Current status entry address |
| pending | output | CNT_W | Descriptors not yet completed |

## Verification
A wrong frame-state register shows up as a misplaced or repeated memory request, or as a status word whose index or result bits disagree with the descriptor and MAC result of the frame in flight, visible at the handshake where it happens. A pointer or counter that slips is exposed on the very next cycle, because the reference model compares desc_cur, stat_cur, pending and tx_irq every clock. An abort flag taken from the wrong bit shows as a MAC start for an aborted frame, or a missing one for a normal frame, before that frame's status is written.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_BUF, S_WT_BUF, S_RD_CTL, S_WT_CTL, S_MAC_GO, S_MAC_WT, S_STAT_WR
  } txr_state_t;

  typedef struct packed {
    logic       ok;
    logic       no_carrier;
    logic       late_coll;
    logic       underrun;
    logic       excess_coll;
    logic [4:0] coll_cnt;
  } mac_res_t;

  // Advance a ring address by one entry, wrapping after the last entry.
  function automatic addr_t ring_step(input addr_t cur, input addr_t base,
                                      input int unsigned stride, input int unsigned entries);
    addr_t last;
    last = base + addr_t'(stride * (entries - 1));
    return (cur == last) ? base : cur + addr_t'(stride);
  endfunction

  // Assemble a completion word.
  function automatic logic [31:0] pack_status(input logic [14:0] idx, input logic aborted,
                                              input mac_res_t r);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30]    = r.ok & ~aborted;
    w[29]    = aborted;
    w[28]    = r.no_carrier;
    w[26]    = r.late_coll;
    w[25]    = r.underrun;
    w[24]    = r.excess_coll;
    w[20:16] = r.coll_cnt;
    w[14:0]  = idx;
    return w;
  endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
#(
  parameter int unsigned STRIDE  = 8,
  parameter int unsigned ENTRIES = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t base_in,
  input  logic  step,
  output addr_t cur
);
  addr_t base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur    <= '0;
    end else if (load) begin
      base_q <= base_in;
      cur    <= base_in;
    end else if (step) begin
      cur <= ring_step(cur, base_q, STRIDE, ENTRIES);
    end
  end
endmodule

// File: rtl/txr_stat_pack.sv
module txr_stat_pack
  import txr_pkg::*;
(
  input  logic [14:0] idx,
  input  logic        aborted,
  input  mac_res_t    res,
  output logic [31:0] word
);
  always_comb word = pack_status(idx, aborted, res);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import txr_pkg::*;
#(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned DESC_BYTES = 8,
  parameter int unsigned STAT_BYTES = 4,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [31:0]       cfg_desc_base,
  input  logic [31:0]       cfg_stat_base,
  input  logic              enq_valid,
  input  logic [CNT_W-1:0]  enq_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              mac_start,
  output logic [31:0]       mac_addr,
  output logic [11:0]       mac_len,
  output logic              mac_eof,
  input  logic              mac_done,
  input  logic              mac_ok,
  input  logic              mac_no_carrier,
  input  logic              mac_late_coll,
  input  logic              mac_underrun,
  input  logic              mac_excess_coll,
  input  logic [4:0]        mac_coll_cnt,
  output logic              tx_irq,
  output logic [31:0]       desc_cur,
  output logic [31:0]       stat_cur,
  output logic [CNT_W-1:0]  pending
);
  localparam int unsigned WORD_BYTES = 4;

  txr_state_t  st, st_n;
  addr_t       buf_q;
  logic        eof_q, abort_q;
  logic [14:0] idx_q;
  logic [11:0] len_q;
  mac_res_t    res_q, res_in;
  logic        mac_issued;
  logic        irq_q;
  logic [CNT_W-1:0] pend_q;
  logic [31:0] stat_word;

  // Named internal events for the checker.
  logic evt_commit, evt_mac_fire, evt_ctl_take;
  assign evt_commit   = (st == S_STAT_WR) && mem_gnt;
  assign evt_mac_fire = (st == S_MAC_GO);
  assign evt_ctl_take = (st == S_WT_CTL) && mem_rvalid;

  logic unused_rdata;
  assign unused_rdata = ^mem_rdata[14:12];

  assign res_in = '{ok: mac_ok, no_carrier: mac_no_carrier, late_coll: mac_late_coll,
                    underrun: mac_underrun, excess_coll: mac_excess_coll,
                    coll_cnt: mac_coll_cnt};

  txr_ring_ptr #(.STRIDE(DESC_BYTES), .ENTRIES(ENTRIES)) u_desc_ptr (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .base_in(cfg_desc_base),
    .step(evt_commit), .cur(desc_cur));

  txr_ring_ptr #(.STRIDE(STAT_BYTES), .ENTRIES(ENTRIES)) u_stat_ptr (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .base_in(cfg_stat_base),
    .step(evt_commit), .cur(stat_cur));

  txr_stat_pack u_pack (.idx(idx_q), .aborted(abort_q), .res(res_q), .word(stat_word));

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:    if (pend_q != '0) st_n = S_RD_BUF;
      S_RD_BUF:  if (mem_gnt) st_n = S_WT_BUF;
      S_WT_BUF:  if (mem_rvalid) st_n = S_RD_CTL;
      S_RD_CTL:  if (mem_gnt) st_n = S_WT_CTL;
      S_WT_CTL:  if (mem_rvalid) st_n = mem_rdata[15] ? S_STAT_WR : S_MAC_GO;
      S_MAC_GO:  st_n = S_MAC_WT;
      S_MAC_WT:  if (mac_done) st_n = S_STAT_WR;
      S_STAT_WR: if (mem_gnt) st_n = S_IDLE;
      default:   st_n = S_IDLE;
    endcase
    if (cfg_load) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      buf_q      <= '0;
      eof_q      <= 1'b0;
      abort_q    <= 1'b0;
      idx_q      <= '0;
      len_q      <= '0;
      res_q      <= '0;
      mac_issued <= 1'b0;
      irq_q      <= 1'b0;
      pend_q     <= '0;
    end else begin
      st    <= st_n;
      irq_q <= evt_commit;
      if (st == S_WT_BUF && mem_rvalid) buf_q <= mem_rdata;
      if (evt_ctl_take) begin
        eof_q   <= mem_rdata[31];
        idx_q   <= mem_rdata[30:16];
        abort_q <= mem_rdata[15];
        len_q   <= mem_rdata[11:0];
        res_q   <= '0;
      end
      if (st == S_MAC_WT && mac_done) res_q <= res_in;
      if (st == S_IDLE) mac_issued <= 1'b0;
      else if (evt_mac_fire) mac_issued <= 1'b1;
      if (cfg_load) pend_q <= '0;
      else pend_q <= pend_q + (enq_valid ? enq_count : CNT_W'(0)) - CNT_W'(evt_commit);
    end
  end

  always_comb begin
    mem_req   = (st == S_RD_BUF) || (st == S_RD_CTL) || (st == S_STAT_WR);
    mem_we    = (st == S_STAT_WR);
    mem_wdata = stat_word;
    unique case (st)
      S_RD_CTL:  mem_addr = desc_cur + addr_t'(WORD_BYTES);
      S_STAT_WR: mem_addr = stat_cur;
      default:   mem_addr = desc_cur;
    endcase
  end

  assign mac_start = evt_mac_fire;
  assign mac_addr  = buf_q;
  assign mac_len   = len_q;
  assign mac_eof   = eof_q;
  assign tx_irq    = irq_q;
  assign pending   = pend_q;
endmodule

// File: rtl/txr_checks.sv
module txr_checks #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mac_start,
  input logic             tx_irq,
  input logic [31:0]      desc_cur,
  input logic [31:0]      stat_cur,
  input logic [CNT_W-1:0] pending,
  input logic             mac_issued
);
  logic unused_wdata;
  assign unused_wdata = ^mem_wdata[28:0];

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cfg_load) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_mac_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> !mac_start);

  assert_stat_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[31] && !(mem_wdata[30] && mem_wdata[29])));

  assert_normal_used_mac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wdata[29]) |-> mac_issued);

  assert_abort_no_mac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata[29]) |-> !mac_issued);

  assert_mac_needs_work_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |-> (pending != '0));

  assert_desc_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_irq && !$past(cfg_load)) |-> $stable(desc_cur));

  assert_stat_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_irq && !$past(cfg_load)) |-> $stable(stat_cur));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt) |=> tx_irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(mem_req && mem_we && mem_gnt));

  assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (pending == '0));
endmodule

bind tx_ring_engine txr_checks #(.CNT_W(CNT_W)) u_txr_checks (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mac_start(mac_start),
  .tx_irq(tx_irq), .desc_cur(desc_cur), .stat_cur(stat_cur), .pending(pending),
  .mac_issued(mac_issued));

// File: tb/tb_tx_ring_engine.sv
`timescale 1ns/1ps
module tb_tx_ring_engine;
  localparam int CNT_W = 4;
  localparam logic [31:0] DBASE = 32'h0000_1000;
  localparam logic [31:0] SBASE = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, enq_valid = 0;
  logic [CNT_W-1:0] enq_count = '0;
  logic [31:0] cfg_desc_base = DBASE, cfg_stat_base = SBASE;
  logic mem_req, mem_we, mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic mac_start, mac_eof, mac_done = 0;
  logic [31:0] mac_addr;
  logic [11:0] mac_len;
  logic mac_ok = 0, mac_no_carrier = 0, mac_late_coll = 0, mac_underrun = 0, mac_excess_coll = 0;
  logic [4:0] mac_coll_cnt = '0;
  logic tx_irq;
  logic [31:0] desc_cur, stat_cur;
  logic [CNT_W-1:0] pending;

  always #2 clk = ~clk;

  tx_ring_engine dut (.*);

  typedef struct {
    int unsigned addr; int len; int idx; bit eof; bit ab;
    bit ok; bit nc; bit late; bit und; bit exc; int coll;
  } frm_t;

  frm_t fq[$];
  logic [31:0] mem [int unsigned];
  int n_chk = 0, n_fail = 0;
  int unsigned m_desc = 0, m_stat = 0;
  int m_pend = 0;
  bit exp_irq = 0;
  int rv_cnt = 0, mac_cnt = 0, gate_ctr = 0, n_rd = 0, rd_phase = 0;
  logic [31:0] rv_data;
  int host_slot = 0, n_frames = 0, cyc = 0;

  task automatic check(input bit pass, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!pass) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input frm_t f);
    int unsigned w;
    w = 32'h8000_0000 + f.idx;
    if (f.ab) w += (1 << 29);
    else w += (f.ok << 30) + (f.nc << 28) + (f.late << 26) + (f.und << 25)
            + (f.exc << 24) + (f.coll << 16);
    return w;
  endfunction

  function automatic int unsigned next_entry(input int unsigned cur, input int unsigned base,
                                             input int unsigned size);
    return base + ((cur - base + size) % (size * 8));
  endfunction

  // Reference model and memory / MAC responders, compared every clock.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_desc = 0; m_stat = 0; m_pend = 0; exp_irq = 0;
      mem_gnt = 0; mem_rvalid = 0; mac_done = 0; rv_cnt = 0; mac_cnt = 0; rd_phase = 0;
    end else begin
      check(tx_irq === exp_irq, "R9", "irq pulse", 32'(tx_irq), 32'(exp_irq));
      check(desc_cur === m_desc, "R7", "desc pointer", desc_cur, m_desc);
      check(stat_cur === m_stat, "R8", "status pointer", stat_cur, m_stat);
      check(32'(pending) === 32'(m_pend), "R2", "pending count", 32'(pending), 32'(m_pend));
      exp_irq = 0;
      if (cfg_load) begin m_desc = cfg_desc_base; m_stat = cfg_stat_base; m_pend = 0; end
      else if (enq_valid) m_pend += int'(enq_count);

      mem_rvalid = 0;
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin mem_rvalid = 1; mem_rdata = rv_data; end
      end

      mac_done = 0;
      if (mac_cnt > 0) begin
        mac_cnt--;
        if (mac_cnt == 0) begin
          mac_done = 1;
          mac_ok = fq[0].ok; mac_no_carrier = fq[0].nc; mac_late_coll = fq[0].late;
          mac_underrun = fq[0].und; mac_excess_coll = fq[0].exc; mac_coll_cnt = 5'(fq[0].coll);
        end
      end
      if (mac_start) begin
        check(fq.size() > 0 && !fq[0].ab, "R6", "mac start only for non-aborted", 32'(mac_start), 0);
        if (fq.size() > 0) begin
          check(mac_addr === fq[0].addr, "R4", "mac address", mac_addr, fq[0].addr);
          check(32'(mac_len) === 32'(fq[0].len), "R4", "mac length", 32'(mac_len), 32'(fq[0].len));
          check(mac_eof === fq[0].eof, "R4", "mac eof", 32'(mac_eof), 32'(fq[0].eof));
        end
        mac_cnt = 2;
      end

      mem_gnt = 0;
      if (mem_req) begin
        gate_ctr++;
        if (gate_ctr % 3 != 2) begin
          mem_gnt = 1;
          if (mem_we) begin
            check(mem_addr === m_stat, "R8", "status write address", mem_addr, m_stat);
            if (fq.size() > 0) begin
              check(mem_wdata === expect_word(fq[0]), fq[0].ab ? "R6" : "R5", "status word",
                    mem_wdata, expect_word(fq[0]));
              void'(fq.pop_front());
            end else check(0, "R5", "status write with no frame", mem_wdata, 0);
            m_stat = next_entry(m_stat, cfg_stat_base, 4);
            m_desc = next_entry(m_desc, cfg_desc_base, 8);
            m_pend--;
            exp_irq = 1;
          end else begin
            check(mem_addr === m_desc + 4 * rd_phase, "R3", "descriptor read address",
                  mem_addr, m_desc + 4 * rd_phase);
            rv_data = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            rv_cnt = 1 + (n_rd % 3);
            n_rd++;
            rd_phase ^= 1;
          end
        end
      end
    end
  end

  task automatic add_frame(input bit ab, input bit ok, input bit nc, input bit late,
                           input bit und, input bit exc, input int coll, input int len,
                           input bit eof);
    frm_t f;
    int unsigned a;
    f.addr = 32'h8000_0000 + n_frames * 32'h800;
    f.len = len; f.idx = (n_frames * 911 + 3) & 32'h7fff; f.eof = eof; f.ab = ab;
    f.ok = ok; f.nc = nc; f.late = late; f.und = und; f.exc = exc; f.coll = coll;
    a = DBASE + 8 * host_slot;
    mem[a] = f.addr;
    mem[a + 4] = (32'(eof) << 31) | (32'(f.idx) << 16) | (32'(ab) << 15)
               | (32'(n_frames % 8) << 12) | 32'(len & 12'hfff);
    fq.push_back(f);
    host_slot = (host_slot + 1) % 8;
    n_frames++;
  endtask

  task automatic enq(input int cnt);
    @(posedge clk); #1;
    enq_valid = 1; enq_count = CNT_W'(cnt);
    @(posedge clk); #1;
    enq_valid = 0; enq_count = '0;
  endtask

  task automatic drain();
    while (fq.size() != 0 || pending != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    bit saw_req;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_req === 0, "R1", "mem_req in reset", 32'(mem_req), 0);
    check(mac_start === 0, "R1", "mac_start in reset", 32'(mac_start), 0);
    check(tx_irq === 0, "R1", "tx_irq in reset", 32'(tx_irq), 0);
    check(pending === 0, "R1", "pending in reset", 32'(pending), 0);
    check(desc_cur === 0 && stat_cur === 0, "R1", "pointers in reset", desc_cur, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(mem_req === 0 && desc_cur === 0, "R1", "idle after reset", 32'(mem_req), 0);

    // R10: load ring bases
    @(posedge clk); #1 cfg_load = 1;
    @(posedge clk); #1 cfg_load = 0;
    @(negedge clk);
    check(desc_cur === DBASE, "R10", "desc base loaded", desc_cur, DBASE);
    check(stat_cur === SBASE, "R10", "status base loaded", stat_cur, SBASE);
    check(pending === 0, "R10", "pending cleared", 32'(pending), 0);

    // R2: a zero count changes nothing
    enq(0);
    saw_req = 0;
    repeat (8) begin @(negedge clk); if (mem_req) saw_req = 1; end
    check(!saw_req, "R2", "no fetch after zero enqueue", 32'(saw_req), 0);
    check(pending === 0, "R2", "pending after zero enqueue", 32'(pending), 0);

    // Three normal frames in one enqueue, varied MAC results (R3 R4 R5)
    add_frame(0, 1, 0, 0, 0, 0, 0, 64, 1);
    add_frame(0, 0, 1, 1, 0, 1, 31, 1514, 1);
    add_frame(0, 1, 0, 0, 1, 0, 3, 4095, 0);
    enq(3);
    drain();

    // Aborted frame then normal frame, back-to-back single enqueues (R6)
    add_frame(1, 1, 1, 1, 1, 1, 17, 200, 1);
    add_frame(0, 1, 0, 0, 0, 0, 1, 60, 1);
    enq(1);
    enq(1);
    drain();

    // Full ring in two enqueues: both pointers wrap (R7 R8)
    for (int k = 0; k < 8; k++)
      add_frame(k == 5, k % 2, k == 2, 0, k == 6, 0, k, 100 + 37 * k, k != 3);
    enq(4);
    enq(4);
    drain();

    add_frame(0, 1, 0, 1, 0, 0, 9, 1, 1);
    add_frame(1, 0, 0, 0, 0, 0, 0, 0, 0);
    add_frame(0, 1, 0, 0, 0, 1, 16, 2044, 1);
    enq(3);
    drain();

    // 16 frames done: both rings are back at their bases (R7 R8), nothing left (R2)
    check(desc_cur === DBASE, "R7", "desc pointer after two laps", desc_cur, DBASE);
    check(stat_cur === SBASE, "R8", "status pointer after two laps", stat_cur, SBASE);
    check(pending === 0 && fq.size() == 0, "R2", "all frames completed", 32'(pending), 0);
    finish_run();
  end
endmodule